// File: doc/BRIEF.md
# Call/Return Stack Guard Unit

This block sits beside a processor's call and return path, on a machine where a call pushes its frame onto a memory stack. When its guard enable is set, it writes a guard word into a slot just below the stack pointer on every call. On every return it reads that slot back and compares it with the word it expects. If the two differ, it raises a fault instead of letting the return finish quietly. While the guard enable is clear, calls and returns pass straight through. They cause no memory traffic and no stall.

The guard word comes from a magic register. A program-start strobe loads that register from a free-running cycle counter, so each program run gets its own value. A second control bit can mix the stack pointer into the word by XOR, which gives each frame depth a different guard. The core holds the call or return while the stall output is high. Stall rises in the cycle the guarded strobe is presented and falls once the single-word memory handshake has completed.

Top module: `stack_guard_unit`

## Requirements
- R1: After reset the magic register is zero, no memory request is active, stall is low, and both the fault pulse and the sticky fault bit are low. The first guarded call with mixing off therefore writes 0.
- R2: With `guard_en_i` low, a call or return strobe raises no memory request, no stall and no fault.
- R3: With `guard_en_i` high, a call strobe raises a write request (`mem_we_o`=1) to address `sp_i - 2`, carrying the current guard word. Address, write flag and data are held until the cycle in which `mem_ready_i` is high.
- R4: With `guard_en_i` high, a return strobe raises a read request (`mem_we_o`=0) to address `sp_i - 2`, the same slot the matching call wrote.
- R5: A guarded return whose read data, in the ready cycle, differs from the expected word produces a `fault_o` pulse exactly one cycle wide. The pulse starts in the cycle after the ready cycle. A matching word produces no pulse.
- R6: `fault_sticky_o` rises together with the fault pulse and holds until `fault_clr_i` is sampled high; it reads low one cycle later. A new fault in the same cycle as a clear wins.
- R7: A `start_i` pulse loads the magic register with the value of `cycle_cnt_i` at that clock edge. With `mix_en_i` low, the guard word equals the magic value.
- R8: With `mix_en_i` high, the guard word is the magic value XOR `sp_i`, both for the word written on a call and for the word expected on a return.
- R9: `op_stall_o` is high in the cycle a guarded strobe is presented and in every cycle the request is outstanding. It is low in the cycle after the ready cycle.
- R10: Call or return strobes that arrive while a request is outstanding are ignored. The request drops in the cycle after the ready cycle and no second request follows.
- R11: A return presented while `guard_en_i` is low never faults, even if the matching call was guarded and the slot was overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_en_i | input | 1 | Control bit enabling guard insertion and checking |
| mix_en_i | input | 1 | Control bit mixing the stack pointer into the guard word |
| start_i | input | 1 | Program-start strobe, loads the magic register |
| cycle_cnt_i | input | 16 | Free-running cycle counter |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| sp_i | input | 16 | Stack pointer accompanying the strobe |
| op_stall_o | output | 1 | Holds the call or return in the core |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Slot address |
| mem_wdata_o | output | 16 | Guard word to store |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_ready_i | input | 1 | Handshake completion |
| fault_o | output | 1 | One-cycle guard fault pulse |
| fault_sticky_o | output | 1 | Sticky fault status |
| fault_clr_i | input | 1 | Clears the sticky status |

## Verification
Stall is combinational and is checked 1 ns after the strobe is driven, in the same cycle. The request, its address and its data appear one edge after the strobe and are checked at the following falling edge. They are checked again in each wait cycle. The request drop, the stall release and the fault pulse all come one edge after the ready cycle and are sampled at the next falling edge. The pulse is checked low again one cycle later. The sticky clear is checked one edge after the clear is sampled. Sweeps cover both mix settings, several stack pointers, ready latencies 0 to 3 and both intact and corrupted slots. Expected words are computed from a counter value the bench captures itself.

// File: rtl/sgu_pkg.sv
package sgu_pkg;
    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,
        SG_STORE = 2'd1,
        SG_LOAD  = 2'd2
    } sg_state_e;
endpackage

// File: rtl/sgu_magic.sv
module sgu_magic #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] cycle_cnt_i,
    input  logic              mix_en_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic [DATA_W-1:0] key_o
);
    typedef struct packed {
        logic [DATA_W-1:0] magic;
    } magic_t;

    magic_t r_d, r_q;
    logic [DATA_W-1:0] sp_fold;

    generate
        if (ADDR_W >= DATA_W) begin : g_trunc
            assign sp_fold = sp_i[DATA_W-1:0];
        end else begin : g_ext
            assign sp_fold = {{(DATA_W-ADDR_W){1'b0}}, sp_i};
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (start_i) r_d.magic = cycle_cnt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign key_o = mix_en_i ? (r_q.magic ^ sp_fold) : r_q.magic;
endmodule

// File: rtl/sgu_fsm.sv
module sgu_fsm
    import sgu_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SLOT_OFFSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_en_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              stall_o,
    output logic              bad_o
);
    typedef struct packed {
        sg_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] word;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [ADDR_W-1:0] slot_addr;
    logic              take;

    assign slot_addr = sp_i - ADDR_W'(SLOT_OFFSET);
    assign take      = guard_en_i && (call_i || ret_i);

    always_comb begin
        r_d   = r_q;
        bad_o = 1'b0;
        unique case (r_q.state)
            SG_IDLE: begin
                if (take) begin
                    r_d.addr  = slot_addr;
                    r_d.word  = key_i;
                    r_d.state = call_i ? SG_STORE : SG_LOAD;
                end
            end
            SG_STORE: begin
                if (mem_ready_i) r_d.state = SG_IDLE;
            end
            SG_LOAD: begin
                if (mem_ready_i) begin
                    r_d.state = SG_IDLE;
                    bad_o     = (mem_rdata_i != r_q.word);
                end
            end
            default: r_d.state = SG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: SG_IDLE, addr: '0, word: '0};
        else        r_q <= r_d;
    end

    assign mem_req_o   = (r_q.state != SG_IDLE);
    assign mem_we_o    = (r_q.state == SG_STORE);
    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = r_q.word;
    assign stall_o     = mem_req_o || take;
endmodule

// File: rtl/sgu_flag.sv
module sgu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic bad_i,
    input  logic clr_i,
    output logic pulse_o,
    output logic sticky_o
);
    typedef struct packed {
        logic pulse;
        logic sticky;
    } flag_t;

    flag_t r_d, r_q;

    always_comb begin
        r_d.pulse = bad_i;
        if (bad_i)      r_d.sticky = 1'b1;
        else if (clr_i) r_d.sticky = 1'b0;
        else            r_d.sticky = r_q.sticky;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pulse_o  = r_q.pulse;
    assign sticky_o = r_q.sticky;
endmodule

// File: rtl/stack_guard_unit.sv
module stack_guard_unit #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SLOT_OFFSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_en_i,
    input  logic              mix_en_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] cycle_cnt_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              op_stall_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              fault_o,
    output logic              fault_sticky_o,
    input  logic              fault_clr_i
);
    logic [DATA_W-1:0] key;
    logic              bad;

    sgu_magic #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) magic_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cycle_cnt_i (cycle_cnt_i),
        .mix_en_i    (mix_en_i),
        .sp_i        (sp_i),
        .key_o       (key)
    );

    sgu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_OFFSET(SLOT_OFFSET)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .guard_en_i  (guard_en_i),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .sp_i        (sp_i),
        .key_i       (key),
        .mem_rdata_i (mem_rdata_i),
        .mem_ready_i (mem_ready_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .stall_o     (op_stall_o),
        .bad_o       (bad)
    );

    sgu_flag flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bad_i    (bad),
        .clr_i    (fault_clr_i),
        .pulse_o  (fault_o),
        .sticky_o (fault_sticky_o)
    );
endmodule

// File: rtl/sgu_checks.sv
module sgu_checks #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              guard_en_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              op_stall_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic              fault_o,
    input logic              fault_sticky_o
);
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_o && !guard_en_i && (call_i || ret_i)) |-> !op_stall_o);

    assert_disabled_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_o && !guard_en_i) |=> !mem_req_o);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    assert_fault_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(mem_req_o && mem_ready_i && !mem_we_o));

    assert_sticky_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> fault_sticky_o);

    assert_stall_covers_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> op_stall_o);

    assert_no_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i) |=> !mem_req_o);
endmodule

bind stack_guard_unit sgu_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .guard_en_i     (guard_en_i),
    .call_i         (call_i),
    .ret_i          (ret_i),
    .op_stall_o     (op_stall_o),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_ready_i    (mem_ready_i),
    .fault_o        (fault_o),
    .fault_sticky_o (fault_sticky_o)
);

// File: tb/stack_guard_unit_tb_top.sv
`timescale 1ns/1ps
module stack_guard_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        guard_en_i = 1'b0, mix_en_i = 1'b0, start_i = 1'b0;
    logic [15:0] cyc = 16'h3A5C;
    logic        call_i = 1'b0, ret_i = 1'b0;
    logic [15:0] sp_i = '0;
    logic        op_stall_o, mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o, mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;
    logic        mem_ready_i = 1'b0;
    logic        fault_o, fault_sticky_o;
    logic        fault_clr_i = 1'b0;

    int checks = 0, failures = 0;
    logic [15:0] mem [0:255];
    logic [15:0] magic_exp = '0;
    bit          clr_at_ready = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 16'd1;

    stack_guard_unit dut_i (
        .clk(clk), .rst_n(rst_n), .guard_en_i(guard_en_i), .mix_en_i(mix_en_i),
        .start_i(start_i), .cycle_cnt_i(cyc), .call_i(call_i), .ret_i(ret_i),
        .sp_i(sp_i), .op_stall_o(op_stall_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i), .fault_o(fault_o),
        .fault_sticky_o(fault_sticky_o), .fault_clr_i(fault_clr_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] key_of(input logic [15:0] sp, input bit mix);
        return mix ? (magic_exp ^ sp) : magic_exp;
    endfunction

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        magic_exp = cyc;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // One call (is_call=1) or return; poke=1 presents a stray strobe while busy.
    task automatic do_op(input bit is_call, input logic [15:0] sp, input int lat,
                         input bit poke, output bit flt);
        logic [15:0] slot;
        slot = sp - 16'd2;
        @(negedge clk);
        call_i = is_call; ret_i = !is_call; sp_i = sp;
        #1;
        chk(op_stall_o == guard_en_i, guard_en_i ? "R9" : "R2", "stall at strobe",
            op_stall_o, guard_en_i);
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0;
        if (guard_en_i) begin
            chk(mem_req_o == 1'b1, is_call ? "R3" : "R4", "req", mem_req_o, 1);
            chk(mem_we_o == is_call, is_call ? "R3" : "R4", "we", mem_we_o, is_call);
            chk(mem_addr_o == slot, is_call ? "R3" : "R4", "addr", mem_addr_o, slot);
            if (is_call)
                chk(mem_wdata_o == key_of(sp, mix_en_i), mix_en_i ? "R8" : "R7",
                    "wdata", mem_wdata_o, key_of(sp, mix_en_i));
            for (int w = 0; w < lat; w++) begin
                if (poke && w == 0) begin call_i = 1'b1; ret_i = 1'b1; end
                @(negedge clk);
                call_i = 1'b0; ret_i = 1'b0;
                chk(mem_req_o && op_stall_o && mem_addr_o == slot, "R9",
                    "held while waiting", {mem_req_o, op_stall_o}, 3);
            end
            mem_ready_i = 1'b1;
            if (clr_at_ready) fault_clr_i = 1'b1;
            if (is_call) mem[slot[8:1]] = mem_wdata_o;
            else         mem_rdata_i = mem[slot[8:1]];
            @(negedge clk);
            mem_ready_i = 1'b0; fault_clr_i = 1'b0;
            chk(!mem_req_o && !op_stall_o, poke ? "R10" : "R9", "release after ready",
                {mem_req_o, op_stall_o}, 0);
            flt = fault_o;
            if (poke) begin
                @(negedge clk);
                chk(!mem_req_o, "R10", "no follow-on req", mem_req_o, 0);
            end
        end else begin
            chk(!mem_req_o, "R2", "no req when disabled", mem_req_o, 0);
            @(negedge clk);
            chk(!mem_req_o && !fault_o, is_call ? "R2" : "R11", "quiet when disabled",
                {mem_req_o, fault_o}, 0);
            flt = fault_o;
        end
    endtask

    task automatic clear_sticky();
        @(negedge clk);
        fault_clr_i = 1'b1;
        @(negedge clk);
        fault_clr_i = 1'b0;
        chk(!fault_sticky_o, "R6", "sticky cleared", fault_sticky_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit f;
        logic [15:0] sps [4];
        sps[0] = 16'h0100; sps[1] = 16'h01F0; sps[2] = 16'h8002; sps[3] = 16'hFFFE;
        for (int i = 0; i < 256; i++) mem[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !op_stall_o && !fault_o && !fault_sticky_o, "R1",
            "reset outputs", {mem_req_o, op_stall_o, fault_o, fault_sticky_o}, 0);
        guard_en_i = 1'b1;
        do_op(1'b1, 16'h0040, 0, 1'b0, f);   // R1: magic zero gives wdata 0
        chk(mem[8'h1F] == 16'h0000, "R1", "zero magic after reset", mem[8'h1F], 0);

        // R2: disabled call and return
        guard_en_i = 1'b0;
        do_op(1'b1, 16'h0080, 0, 1'b0, f);
        do_op(1'b0, 16'h0080, 0, 1'b0, f);

        // Main sweep: R3 R4 R5 R6 R7 R8 R9
        for (int mx = 0; mx < 2; mx++)
            for (int s = 0; s < 4; s++)
                for (int lat = 0; lat < 4; lat++)
                    for (int bad = 0; bad < 2; bad++) begin
                        logic [15:0] slot;
                        guard_en_i = 1'b1;
                        mix_en_i = mx[0];
                        do_start();
                        do_op(1'b1, sps[s], lat, 1'b0, f);
                        slot = sps[s] - 16'd2;
                        if (bad != 0) mem[slot[8:1]] ^= (16'h0001 << ((s*4 + lat) % 16));
                        do_op(1'b0, sps[s], lat, 1'b0, f);
                        chk(f == bad[0], "R5", "fault pulse", f, bad);
                        chk(fault_sticky_o == bad[0], "R6", "sticky set", fault_sticky_o, bad);
                        @(negedge clk);
                        chk(!fault_o, "R5", "pulse one cycle", fault_o, 0);
                        chk(fault_sticky_o == bad[0], "R6", "sticky holds", fault_sticky_o, bad);
                        if (bad != 0) clear_sticky();
                    end

        // R10: stray strobes during an outstanding request
        mix_en_i = 1'b0;
        do_start();
        do_op(1'b1, 16'h0200, 3, 1'b1, f);
        do_op(1'b0, 16'h0200, 2, 1'b1, f);
        chk(!f, "R10", "return after stray strobes matches", f, 0);

        // R6: fault and clear in the same cycle, fault wins
        do_op(1'b1, 16'h0300, 1, 1'b0, f);
        mem[8'h7F] ^= 16'h8000;
        clr_at_ready = 1'b1;
        do_op(1'b0, 16'h0300, 1, 1'b0, f);
        clr_at_ready = 1'b0;
        chk(f && fault_sticky_o, "R6", "set wins over clear", {f, fault_sticky_o}, 3);
        clear_sticky();

        // R11: guarded call, corrupted slot, return with guard disabled
        do_op(1'b1, 16'h0400, 0, 1'b0, f);
        mem[8'hFF] ^= 16'h00FF;
        guard_en_i = 1'b0;
        do_op(1'b0, 16'h0400, 0, 1'b0, f);
        chk(!f && !fault_sticky_o, "R11", "no fault with guard off",
            {f, fault_sticky_o}, 0);

        // R7: reload via start changes the word written
        guard_en_i = 1'b1;
        do_start();
        do_op(1'b1, 16'h0500, 0, 1'b0, f);
        chk(mem[8'h7F] == magic_exp, "R7", "reloaded magic", mem[8'h7F], magic_exp);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule